// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the address for one port of a synchronous dual-port memory. An external address can be loaded, and the block then steps it by one on each enabled clock. A mask register picks which low-order bits take part in the count. The high-order bits outside the mask stay fixed at the loaded value, so a burst runs inside an aligned window of 2^n words.

When the counted field reaches its top value, the block drives an active-low interrupt. If stepping goes on after that, the counter returns to the address that was last loaded from outside, so the same window is sent again. A mirror register holds that last loaded address.

The readback output shows either the counter or the mask, as the counter/mask select chooses. A counter clear sets the counter to zero with no lost cycle. An asynchronous master reset puts every register into its known state.

Top module: `burst_addr_gen`

## Requirements
- R1: When `strobe` is 1, `sel_mask` is 0 and `cnt_clr` is 0 at a clock edge, `mem_addr` equals the sampled `addr_in` after that edge, and the mirror copy is set to that same value. `irq_n` returns to 1.
- R2: When `cnt_en` is 1, `strobe` is 0 and `cnt_clr` is 0, and the masked field of the counter is below the mask, the counter advances by exactly one. The bits outside the mask stay unchanged.
- R3: With `strobe`, `cnt_en` and `cnt_clr` all 0, the counter, the mask, the mirror copy and `irq_n` all keep their values, for any number of cycles.
- R4: When `strobe` is 1, `sel_mask` is 1 and `cnt_clr` is 0, `addr_in` is written into the mask, but only if it has the form 2^n-1 (n from 0 to 18). Any other value leaves the mask unchanged. The counter is not changed in either case.
- R5: While `rst_n` is 0, the mask reads all ones (0x3FFFF), the counter reads 0 and `irq_n` is 1. This takes effect without waiting for a clock edge.
- R6: When a step makes the masked field equal to the mask, `irq_n` is 0 from the next cycle on. It stays 0 until a counter load, a counter clear or a master reset.
- R7: A step taken while the masked field already equals the mask reloads the counter from the mirror copy, which is the last externally loaded address. A mask of zero makes every step such a reload.
- R8: `cnt_clr` has priority over `strobe` and `cnt_en`. It sets the counter and the mirror copy to 0 after the edge and sets `irq_n` to 1, and the access in the next cycle uses address 0.
- R9: `rd_val` shows the mask when `sel_mask` is 1 and the counter when `sel_mask` is 0. It follows `sel_mask` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| addr_in | input | 18 | External address, or mask value for a mask load |
| strobe | input | 1 | Load request: loads the counter, or the mask when `sel_mask` is 1 |
| cnt_en | input | 1 | Step the counter |
| sel_mask | input | 1 | 1 selects the mask for loading and readback |
| cnt_clr | input | 1 | Synchronous counter clear |
| mem_addr | output | 18 | Address for the memory array (the counter) |
| rd_val | output | 18 | Readback of the counter or the mask |
| irq_n | output | 1 | Counter-top interrupt, active low |

## Verification
The hardest state to reach is the retransmit reload. It needs a legal narrow mask, a load, and then an unbroken run of steps through the top of the window. The random mix therefore draws masks mostly of width 0 to 5 bits and makes stepping the most likely operation, so wraps and interrupts happen often. Directed sequences cover the remaining corners: a full-width window at 0x3FFFE, a zero mask, an illegal mask value, and a clear that arrives together with a load.

// File: rtl/bac_pkg.sv
package bac_pkg;
  localparam int ADDR_W = 18;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_CLEAR,
    OP_LOAD,
    OP_MASK,
    OP_STEP
  } op_t;

  // A mask is usable only when it is a solid run of ones from bit 0.
  function automatic logic mask_ok(addr_t v);
    return (v & (v + addr_t'(1))) == '0;
  endfunction

  // The counted field already holds its highest value.
  function automatic logic at_top(addr_t c, addr_t m);
    return (c & m) == m;
  endfunction

  // Add one inside the mask and keep the bits outside it.
  function automatic addr_t step_in_mask(addr_t c, addr_t m);
    return (c & ~m) | ((c + addr_t'(1)) & m);
  endfunction
endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import bac_pkg::*;
(
  input  logic strobe,
  input  logic cnt_en,
  input  logic sel_mask,
  input  logic cnt_clr,
  output op_t  op
);
  always_comb begin
    if (cnt_clr)                 op = OP_CLEAR;
    else if (strobe && sel_mask) op = OP_MASK;
    else if (strobe)             op = OP_LOAD;
    else if (cnt_en)             op = OP_STEP;
    else                         op = OP_HOLD;
  end
endmodule

// File: rtl/bac_mask_reg.sv
module bac_mask_reg
  import bac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  op_t   op,
  input  addr_t din,
  output addr_t mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            mask_q <= '1;
    else if (op == OP_MASK && mask_ok(din)) mask_q <= din;
  end
endmodule

// File: rtl/bac_counter.sv
module bac_counter
  import bac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  op_t   op,
  input  addr_t din,
  input  addr_t mask,
  output addr_t cnt_q,
  output addr_t mirror_q,
  output logic  irq_n,
  output logic  wrap_ev,
  output logic  irq_set_ev
);
  addr_t stepped;

  assign stepped    = step_in_mask(cnt_q, mask);
  assign wrap_ev    = (op == OP_STEP) && at_top(cnt_q, mask);
  assign irq_set_ev = (op == OP_STEP) && !wrap_ev && at_top(stepped, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      mirror_q <= '0;
      irq_n    <= 1'b1;
    end else begin
      unique case (op)
        OP_CLEAR: begin
          cnt_q    <= '0;
          mirror_q <= '0;
          irq_n    <= 1'b1;
        end
        OP_LOAD: begin
          cnt_q    <= din;
          mirror_q <= din;
          irq_n    <= 1'b1;
        end
        OP_STEP: begin
          cnt_q <= wrap_ev ? mirror_q : stepped;
          if (irq_set_ev) irq_n <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe,
  input  logic              cnt_en,
  input  logic              sel_mask,
  input  logic              cnt_clr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] rd_val,
  output logic              irq_n
);
  op_t   op;
  addr_t mask_q;
  addr_t cnt_q;
  addr_t mirror_q;
  logic  wrap_ev;
  logic  irq_set_ev;

  bac_decode u_dec (
    .strobe(strobe), .cnt_en(cnt_en), .sel_mask(sel_mask),
    .cnt_clr(cnt_clr), .op(op)
  );

  bac_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .op(op), .din(addr_in), .mask_q(mask_q)
  );

  bac_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .op(op), .din(addr_in), .mask(mask_q),
    .cnt_q(cnt_q), .mirror_q(mirror_q), .irq_n(irq_n),
    .wrap_ev(wrap_ev), .irq_set_ev(irq_set_ev)
  );

  assign mem_addr = cnt_q;
  assign rd_val   = sel_mask ? mask_q : cnt_q;
endmodule

// File: rtl/bac_checker.sv
module bac_checker
  import bac_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input addr_t addr_in,
  input logic  strobe,
  input logic  cnt_en,
  input logic  sel_mask,
  input logic  cnt_clr,
  input addr_t mem_addr,
  input logic  irq_n,
  input addr_t mask_q,
  input addr_t mirror_q,
  input logic  wrap_ev,
  input logic  irq_set_ev
);
  logic do_load, do_step, do_hold;
  assign do_load = strobe && !sel_mask && !cnt_clr;
  assign do_step = cnt_en && !strobe && !cnt_clr;
  assign do_hold = !strobe && !cnt_en && !cnt_clr;

  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (mem_addr == $past(addr_in)) && (mirror_q == $past(addr_in)) && irq_n);

  a_r2_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && !wrap_ev) |=> ((mem_addr & ~mask_q) == ($past(mem_addr) & ~mask_q)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    do_hold |=> $stable(mem_addr) && $stable(mask_q) && $stable(mirror_q) && $stable(irq_n));

  a_r4_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & (mask_q + addr_t'(1))) == '0));

  a_r6_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_ev |=> !irq_n);

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (mem_addr == $past(mirror_q)));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (mem_addr == '0) && (mirror_q == '0) && irq_n);
endmodule

bind burst_addr_gen bac_checker u_chk (
  .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe(strobe),
  .cnt_en(cnt_en), .sel_mask(sel_mask), .cnt_clr(cnt_clr),
  .mem_addr(mem_addr), .irq_n(irq_n), .mask_q(mask_q),
  .mirror_q(mirror_q), .wrap_ev(wrap_ev), .irq_set_ev(irq_set_ev)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
  import bac_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  addr_t addr_in = '0;
  logic strobe = 0, cnt_en = 0, sel_mask = 0, cnt_clr = 0;
  addr_t mem_addr, rd_val;
  logic irq_n;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model state
  addr_t m_cnt, m_mask, m_mir;
  logic  m_irq;

  always #4 clk = ~clk;

  burst_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe(strobe),
    .cnt_en(cnt_en), .sel_mask(sel_mask), .cnt_clr(cnt_clr),
    .mem_addr(mem_addr), .rd_val(rd_val), .irq_n(irq_n)
  );

  function automatic bit legal(addr_t v);
    for (int k = 0; k <= ADDR_W; k++)
      if ({1'b0, v} == ((19'd1 << k) - 19'd1)) return 1;
    return 0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_mask = '1; m_mir = '0; m_irq = 1'b1;
  endtask

  task automatic model_edge();
    if (cnt_clr) begin
      m_cnt = '0; m_mir = '0; m_irq = 1'b1;
    end else if (strobe && sel_mask) begin
      if (legal(addr_in)) m_mask = addr_in;
    end else if (strobe) begin
      m_cnt = addr_in; m_mir = addr_in; m_irq = 1'b1;
    end else if (cnt_en) begin
      if ((m_cnt & m_mask) == m_mask) m_cnt = m_mir;
      else begin
        m_cnt = m_cnt + 1'b1;
        if ((m_cnt & m_mask) == m_mask) m_irq = 1'b0;
      end
    end
  endtask

  task automatic compare_all(string tag);
    check({tag, " mem_addr R1 R2 R7 R8"}, 32'(mem_addr), 32'(m_cnt));
    check({tag, " irq_n R6"}, 32'(irq_n), 32'(m_irq));
    check({tag, " rd_val R9"}, 32'(rd_val), sel_mask ? 32'(m_mask) : 32'(m_cnt));
  endtask

  // drive at negedge, clock, update model, compare at the next negedge
  task automatic cycle(logic s, logic e, logic sm, logic c, addr_t a, string tag);
    strobe = s; cnt_en = e; sel_mask = sm; cnt_clr = c; addr_in = a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R5: reset state
    sel_mask = 1;
    #1;
    check("R5 mask reset", 32'(rd_val), 32'h3FFFF);
    check("R5 counter reset", 32'(mem_addr), 0);
    check("R5 irq reset", 32'(irq_n), 1);
    sel_mask = 0;
    rst_n = 1;
    @(negedge clk);

    // R1 load, R2 step
    cycle(1, 0, 0, 0, 18'h12340, "R1 load");
    cycle(0, 1, 0, 0, '0, "R2 step");
    check("R2 step value", 32'(mem_addr), 32'h12341);
    // R4 mask 3, then R6/R7 wrap inside window
    cycle(1, 0, 1, 0, 18'h00003, "R4 mask");
    check("R4 mask readback", 32'(rd_val), 3);
    check("R4 counter untouched", 32'(mem_addr), 32'h12341);
    cycle(1, 0, 0, 0, 18'h2AB41, "R1 load2");
    cycle(0, 1, 0, 0, '0, "R2");
    cycle(0, 1, 0, 0, '0, "R6");
    check("R6 irq at top", 32'(irq_n), 0);
    check("R2 upper kept", 32'(mem_addr), 32'h2AB43);
    cycle(0, 0, 0, 0, '0, "R3 hold");
    check("R3 hold irq", 32'(irq_n), 0);
    cycle(0, 1, 0, 0, '0, "R7 wrap");
    check("R7 wrap to mirror", 32'(mem_addr), 32'h2AB41);
    check("R6 irq stays low", 32'(irq_n), 0);
    // R4 illegal mask ignored
    cycle(1, 0, 1, 0, 18'h00005, "R4 illegal");
    check("R4 illegal ignored", 32'(rd_val), 3);
    // R8 clear beats load
    cycle(1, 1, 0, 1, 18'h11111, "R8 clr");
    check("R8 clear priority", 32'(mem_addr), 0);
    check("R8 irq cleared", 32'(irq_n), 1);
    // R7 zero mask
    cycle(1, 0, 1, 0, 18'h00000, "R4 zero");
    cycle(1, 0, 0, 0, 18'h00777, "R1");
    cycle(0, 1, 0, 0, '0, "R7 zero mask");
    check("R7 zero mask reload", 32'(mem_addr), 32'h00777);
    // full-width window near top
    cycle(1, 0, 1, 0, 18'h3FFFF, "R4 full");
    cycle(1, 0, 0, 0, 18'h3FFFE, "R1");
    cycle(0, 1, 0, 0, '0, "R6 full");
    check("R6 full irq", 32'(irq_n), 0);
    cycle(0, 1, 0, 0, '0, "R7 full");
    check("R7 full wrap", 32'(mem_addr), 32'h3FFFE);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      addr_t a = addr_t'($urandom);
      logic s = 0, e = 0, sm = logic'($urandom_range(0, 1)), c = 0;
      if (r < 2) c = 1;
      else if (r < 17) begin
        s = 1;
        if (sm && $urandom_range(0, 9) < 8)
          a = addr_t'((19'd1 << $urandom_range(0, 5)) - 19'd1);
      end else if (r < 85) e = 1;
      cycle(s, e, sm, c, a, "rand");
    end

    // R5 asynchronous reset mid-run
    #2 rst_n = 0;
    #1;
    model_reset();
    sel_mask = 1;
    #0.5;
    check("R5 async mask", 32'(rd_val), 32'h3FFFF);
    check("R5 async cnt", 32'(mem_addr), 0);
    check("R5 async irq", 32'(irq_n), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule